// File: doc/BRIEF.md
# Dual-modulus alternating clock divider

This block derives a slower clock, or a clock enable, from a fast input clock. In single mode the output period is one programmed integer number of input cycles. In dual mode the block emits a programmed number of output periods at a first divisor, then a programmed number at a second divisor, and repeats that sequence. The average output frequency is therefore a fraction of the input clock that no single integer ratio can give.

All four programmable fields are held as the value minus one. The block keeps a shadow copy of the mode bit and the fields. It takes in new values only at the end of a complete sequence in dual mode, or at the end of a period in single mode, so a period is never cut short. Each output period is high for its first floor(N/2) input cycles. A divisor of one gives an output that stays high, which acts as an enable on every input cycle.

Top module: `dualmod_clkdiv`

## Requirements
- R1: A field holding value v stands for v+1. In single mode (`blend_en`=0) every output period lasts exactly `ratio_a_m1`+1 input cycles.
- R2: In single mode the fields `ratio_b_m1`, `repeat_a_m1` and `repeat_b_m1` have no effect on the output waveform.
- R3: In dual mode (`blend_en`=1) the output gives M1=`repeat_a_m1`+1 periods of N1=`ratio_a_m1`+1 cycles each, then M2=`repeat_b_m1`+1 periods of N2=`ratio_b_m1`+1 cycles each, and then starts the sequence again.
- R4: In dual mode with N1 and N2 both at least 2, every sequence of N1*M1+N2*M2 input cycles holds exactly M1+M2 rising edges of `div_out`. The long-run rate is therefore f_in*(M1+M2)/(N1*M1+N2*M2).
- R5: Within a period at divisor N, `div_out` is high for input cycles 0 to floor(N/2)-1 and low for the rest. When N=1, `div_out` stays high.
- R6: Changes to the mode bit or to any field take effect only from the first period after the current sequence ends (dual mode) or after the current period ends (single mode).
- R7: While `rst_n` is low, `div_out` is low and the shadow configuration copies the inputs. Cycle 0 of the first period is driven after the first rising clock edge at which `rst_n` is high.
- R8: The fields are 12 bits wide, so the stored value 4095 gives a divisor or repeat count of 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| blend_en | input | 1 | 1 selects dual (alternating) mode, 0 selects single mode |
| ratio_a_m1 | input | 12 | First divisor minus one |
| ratio_b_m1 | input | 12 | Second divisor minus one |
| repeat_a_m1 | input | 12 | Periods at the first divisor, minus one |
| repeat_b_m1 | input | 12 | Periods at the second divisor, minus one |
| div_out | output | 1 | Divided clock or enable |

## Verification
`div_out` comes from registered state. After `rst_n` rises on a falling edge, the bench samples on every later falling edge. The first such sample is cycle 0 of the first period, and sample k is compared with the pattern value at index k, which the bench computes from the field values alone. A configuration change is applied right after a chosen sample in the middle of a sequence. From the requirements, the old pattern must last until the sample that ends the sequence, and the new pattern must start on the very next sample. The bench counts rising edges over whole sequences and compares the count with M1+M2 per sequence.

// File: rtl/dmdiv_pkg.sv
// Shared definitions for the dual-modulus divider.
// Assumes: all fields share one width; phase is a single bit.
package dmdiv_pkg;

    // Default width of the divisor and repeat fields
    parameter int unsigned DMD_FIELD_W = 12;

    // Which divisor the current output period uses
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } dmd_phase_e;

endpackage

// File: rtl/dmdiv_cfg_shadow.sv
// Shadow copy of the mode bit and the four fields.
// The copy follows the inputs during reset and otherwise loads only
// when load_i is high, which the top drives at a sequence boundary.
// Assumes: load_i is a one-cycle strobe from the sequencer.
module dmdiv_cfg_shadow #(
    parameter int unsigned FIELD_W = dmdiv_pkg::DMD_FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               dual_i,
    input  logic [FIELD_W-1:0] na_i,
    input  logic [FIELD_W-1:0] nb_i,
    input  logic [FIELD_W-1:0] ma_i,
    input  logic [FIELD_W-1:0] mb_i,
    output logic               dual_o,
    output logic [FIELD_W-1:0] na_o,
    output logic [FIELD_W-1:0] nb_o,
    output logic [FIELD_W-1:0] ma_o,
    output logic [FIELD_W-1:0] mb_o
);

    // Capture the configuration in reset or at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            dual_o <= dual_i;
            na_o   <= na_i;
            nb_o   <= nb_i;
            ma_o   <= ma_i;
            mb_o   <= mb_i;
        end
    end

endmodule

// File: rtl/dmdiv_period_ctr.sv
// Counts input cycles within one output period and forms the waveform.
// The output is high for the first floor(N/2) cycles of the period,
// or all the time when N is 1. running_o goes high on the first clock
// after reset, and cycle 0 of the first period starts at that point.
// Assumes: n_m1_i changes only when the counter goes back to cycle 0.
module dmdiv_period_ctr #(
    parameter int unsigned FIELD_W = dmdiv_pkg::DMD_FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] n_m1_i,
    output logic               running_o,
    output logic               period_end_o,
    output logic               wave_o
);

    localparam int unsigned SUM_W = FIELD_W + 1;

    logic [FIELD_W-1:0] cyc_q;
    logic [SUM_W-1:0]   n_full;
    logic [FIELD_W-1:0] half_n;
    logic               n_is_one;

    // Divisor value and half of it, rounded down
    always_comb begin
        n_full   = {1'b0, n_m1_i} + SUM_W'(1);
        half_n   = n_full[SUM_W-1:1];
        n_is_one = (n_m1_i == '0);
    end

    // End of period flag
    assign period_end_o = running_o && (cyc_q == n_m1_i);

    // Start-up flag and cycle counter within the period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_o <= 1'b0;
            cyc_q     <= '0;
        end else if (!running_o) begin
            running_o <= 1'b1;
        end else if (period_end_o) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + FIELD_W'(1);
        end
    end

    // Waveform: high during the first half, held high for a divisor of 1
    assign wave_o = running_o && (n_is_one || (cyc_q < half_n));

    // R1: the cycle counter never passes the current divisor
    p_cyc_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (cyc_q <= n_m1_i));

    // R5: a rising edge of the waveform only occurs at cycle 0 of a period
    p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $rose(wave_o)) |-> (cyc_q == '0));

endmodule

// File: rtl/dmdiv_phase_seq.sv
// Counts periods within a phase and switches between the two divisors.
// In dual mode each phase lasts its own repeat count of periods. In
// single mode the phase stays at the first divisor.
// seq_end_o marks the last cycle of a whole sequence, or of a period in
// single mode.
// Assumes: dual_i, ma_i and mb_i change only when seq_end_o is high.
module dmdiv_phase_seq #(
    parameter int unsigned FIELD_W = dmdiv_pkg::DMD_FIELD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   period_end_i,
    input  logic                   dual_i,
    input  logic [FIELD_W-1:0]     ma_i,
    input  logic [FIELD_W-1:0]     mb_i,
    output dmdiv_pkg::dmd_phase_e  phase_o,
    output logic                   seq_end_o
);

    import dmdiv_pkg::*;

    logic [FIELD_W-1:0] rep_q;
    logic [FIELD_W-1:0] rep_lim;
    logic               phase_last;

    // Repeat limit of the current phase
    always_comb begin
        rep_lim    = (phase_o == PH_SECOND) ? mb_i : ma_i;
        phase_last = (rep_q == rep_lim);
    end

    // A sequence ends after the last period of the second phase
    assign seq_end_o = period_end_i &&
                       (!dual_i || ((phase_o == PH_SECOND) && phase_last));

    // Period counter and phase selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q   <= '0;
            phase_o <= PH_FIRST;
        end else if (period_end_i) begin
            if (!dual_i) begin
                rep_q   <= '0;
                phase_o <= PH_FIRST;
            end else if (phase_last) begin
                rep_q   <= '0;
                phase_o <= (phase_o == PH_FIRST) ? PH_SECOND : PH_FIRST;
            end else begin
                rep_q <= rep_q + FIELD_W'(1);
            end
        end
    end

    // R3: the period count stays within the limit of its phase
    p_rep_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q <= rep_lim);

    // R2: single mode never leaves the first divisor
    p_single_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_i |-> (phase_o == PH_FIRST));

endmodule

// File: rtl/dualmod_clkdiv.sv
// Dual-modulus alternating clock divider, top level.
// The shadow configuration feeds the sequencer and the period counter.
// The sequencer picks the divisor for each period. The shadow copy
// reloads from the ports at every sequence boundary.
// Assumes: one clock domain; the output is used as a clock enable or is
// retimed downstream.
module dualmod_clkdiv #(
    parameter int unsigned FIELD_W = dmdiv_pkg::DMD_FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blend_en,
    input  logic [FIELD_W-1:0] ratio_a_m1,
    input  logic [FIELD_W-1:0] ratio_b_m1,
    input  logic [FIELD_W-1:0] repeat_a_m1,
    input  logic [FIELD_W-1:0] repeat_b_m1,
    output logic               div_out
);

    import dmdiv_pkg::*;

    logic               act_dual;
    logic [FIELD_W-1:0] act_na;
    logic [FIELD_W-1:0] act_nb;
    logic [FIELD_W-1:0] act_ma;
    logic [FIELD_W-1:0] act_mb;
    logic [FIELD_W-1:0] n_cur;
    logic               running;
    logic               period_end;
    logic               seq_end;
    dmd_phase_e         phase;

    // Shadow configuration, reloaded at sequence boundaries
    dmdiv_cfg_shadow #(.FIELD_W(FIELD_W)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (seq_end),
        .dual_i (blend_en),
        .na_i   (ratio_a_m1),
        .nb_i   (ratio_b_m1),
        .ma_i   (repeat_a_m1),
        .mb_i   (repeat_b_m1),
        .dual_o (act_dual),
        .na_o   (act_na),
        .nb_o   (act_nb),
        .ma_o   (act_ma),
        .mb_o   (act_mb)
    );

    // Divisor of the current period
    assign n_cur = (act_dual && (phase == PH_SECOND)) ? act_nb : act_na;

    // Input-cycle counter and waveform
    dmdiv_period_ctr #(.FIELD_W(FIELD_W)) per_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .n_m1_i       (n_cur),
        .running_o    (running),
        .period_end_o (period_end),
        .wave_o       (div_out)
    );

    // Phase and repeat sequencing
    dmdiv_phase_seq #(.FIELD_W(FIELD_W)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_end_i (period_end),
        .dual_i       (act_dual),
        .ma_i         (act_ma),
        .mb_i         (act_mb),
        .phase_o      (phase),
        .seq_end_o    (seq_end)
    );

    // R6: the shadow configuration holds outside a sequence boundary
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(seq_end)) |->
        ($stable(act_dual) && $stable(act_na) && $stable(act_nb) &&
         $stable(act_ma) && $stable(act_mb)));

    // R3: the phase changes only at the end of a period
    p_phase_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (phase != $past(phase))) |-> $past(period_end));

    // R7: the first cycle after reset is the start of a period
    p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !div_out);

endmodule

// File: tb/dualmod_clkdiv_tb_top.sv
// Self-checking bench: sweeps small configurations and compares every
// output cycle with a pattern computed from the field values.
module dualmod_clkdiv_tb_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blend_en = 1'b0;
    logic [W-1:0] ratio_a_m1 = '0;
    logic [W-1:0] ratio_b_m1 = '0;
    logic [W-1:0] repeat_a_m1 = '0;
    logic [W-1:0] repeat_b_m1 = '0;
    logic         div_out;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    dualmod_clkdiv #(.FIELD_W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .blend_en    (blend_en),
        .ratio_a_m1  (ratio_a_m1),
        .ratio_b_m1  (ratio_b_m1),
        .repeat_a_m1 (repeat_a_m1),
        .repeat_b_m1 (repeat_b_m1),
        .div_out     (div_out)
    );

    // Record one check
    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected output at sample index idx for real values N1,N2,M1,M2
    function automatic logic pat(bit d, int n1, int n2, int m1, int m2, int idx);
        int len;
        int r;
        int c;
        len = d ? (n1 * m1 + n2 * m2) : n1;
        r = idx % len;
        if (!d || r < n1 * m1) begin
            c = r % n1;
            return (n1 == 1) || (c < n1 / 2);
        end
        c = (r - n1 * m1) % n2;
        return (n2 == 1) || (c < n2 / 2);
    endfunction

    task automatic drive(bit d, int n1, int n2, int m1, int m2);
        blend_en    = d;
        ratio_a_m1  = W'(n1 - 1);
        ratio_b_m1  = W'(n2 - 1);
        repeat_a_m1 = W'(m1 - 1);
        repeat_b_m1 = W'(m2 - 1);
    endtask

    task automatic do_reset(bit d, int n1, int n2, int m1, int m2);
        @(negedge clk);
        rst_n = 1'b0;
        drive(d, n1, n2, m1, m2);
        repeat (3) @(negedge clk);
        chk(div_out == 1'b0, "R7 output low in reset", int'(div_out), 0);
        rst_n = 1'b1;
    endtask

    // Run nseq sequences of one fixed configuration
    task automatic run_cfg(bit d, int n1, int n2, int m1, int m2, int nseq,
                           string req);
        int len;
        int bad;
        int edges;
        logic prev;
        logic e;
        do_reset(d, n1, n2, m1, m2);
        len = d ? (n1 * m1 + n2 * m2) : n1;
        bad = 0;
        edges = 0;
        prev = 1'b0;
        for (int i = 0; i < nseq * len; i++) begin
            @(negedge clk);
            e = pat(d, n1, n2, m1, m2, i);
            if (div_out !== e) bad++;
            if (div_out && !prev) edges++;
            prev = div_out;
        end
        chk(bad == 0, req, bad, 0);
        if (d && n1 >= 2 && n2 >= 2)
            chk(edges == nseq * (m1 + m2), "R4 edges per sequence", edges,
                nseq * (m1 + m2));
        if (!d && n1 >= 2)
            chk(edges == nseq, "R1 edges per period", edges, nseq);
    endtask

    // Change the configuration after sample j, in the middle of the first
    // sequence. The old pattern must run to the end of that sequence.
    task automatic run_switch(bit da, int a1, int a2, int am1, int am2,
                              bit db, int b1, int b2, int bm1, int bm2,
                              int j, int nb, string req);
        int la;
        int lb;
        int bad;
        logic e;
        do_reset(da, a1, a2, am1, am2);
        la = da ? (a1 * am1 + a2 * am2) : a1;
        lb = db ? (b1 * bm1 + b2 * bm2) : b1;
        bad = 0;
        for (int i = 0; i < la + nb * lb; i++) begin
            @(negedge clk);
            if (i < la) e = pat(da, a1, a2, am1, am2, i);
            else        e = pat(db, b1, b2, bm1, bm2, i - la);
            if (div_out !== e) bad++;
            if (i == j) drive(db, b1, b2, bm1, bm2);
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        // R1 and R5: single mode over a range of divisors
        for (int n = 1; n <= 8; n++)
            run_cfg(1'b0, n, 3, 2, 2, 3, "R1 R5 single-mode pattern");

        // R2: single mode with extreme values in the unused fields
        run_cfg(1'b0, 5, 4096, 4096, 4096, 4, "R2 unused fields ignored");
        run_cfg(1'b0, 5, 1, 1, 1, 4, "R2 unused fields ignored (min)");

        // R3, R4 and R5: dual-mode sweep
        for (int n1 = 1; n1 <= 4; n1++)
            for (int n2 = 1; n2 <= 4; n2++)
                for (int m1 = 1; m1 <= 3; m1++)
                    for (int m2 = 1; m2 <= 3; m2++)
                        run_cfg(1'b1, n1, n2, m1, m2, 3, "R3 R5 dual-mode pattern");

        // R6: mid-sequence changes wait for the boundary
        run_switch(1'b1, 3, 2, 2, 3, 1'b1, 4, 5, 1, 2, 4, 2,
                   "R6 dual to dual at sequence end");
        run_switch(1'b1, 2, 3, 3, 1, 1'b0, 5, 1, 1, 1, 6, 3,
                   "R6 dual to single at sequence end");
        run_switch(1'b0, 6, 1, 1, 1, 1'b1, 2, 3, 2, 2, 2, 2,
                   "R6 single to dual at period end");
        run_switch(1'b0, 7, 1, 1, 1, 1'b0, 3, 9, 9, 9, 0, 3,
                   "R6 single divisor change at period end");

        // R8: full-width field values
        run_cfg(1'b0, 4096, 1, 1, 1, 2, "R8 divisor 4096 single");
        run_cfg(1'b1, 4096, 2, 1, 1, 1, "R8 divisor 4096 dual");
        run_cfg(1'b1, 1, 2, 4096, 1, 1, "R8 repeat 4096 dual");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule